// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block sits between a synchronous host and a 16-bit asynchronous static RAM. The host presents one word request at a time: an address, write data, a two-bit lane mask and a read/write flag. The controller turns each request into a timed sequence on the memory's active-low strobes: chip select, output enable, write enable and two byte enables. It also owns the data bus through separate drive-value, drive-enable and sample signals. When the access is finished it pulses `done` for one cycle and, for reads, presents the captured word.

All memory timing is expressed as whole clock counts, rounded up from the memory's nanosecond figures. At 250 MHz the defaults are a 2-cycle write strobe, a 2-cycle data setup, a 3-cycle read window and a 2-cycle bus turnaround. After reset no access can start until a power-up interval of `CLK_MHZ * PWRUP_US` cycles has passed. Lanes that the mask leaves out are neither written nor returned.

Top module: `sram_strobe_ctrl`

## Requirements
- R1: After reset, `ready` stays low and chip select stays high for exactly `CLK_MHZ*PWRUP_US` clock edges, and requests made in that time have no effect. `ready` then rises and stays high whenever the sequencer is idle.
- R2: A write drives chip select and write enable low together for `max(CYC_WE, CYC_DSU)` cycles. It also drives byte enable low for each set mask bit (bit 0 selects data bits 7:0, bit 1 selects bits 15:8). Chip select and the bus drive stay active for one further cycle after write enable rises.
- R3: Output enable is high in every cycle in which write enable is low, and the bus is never driven while output enable is low.
- R4: A read holds write enable high with chip select and output enable low for `CYC_ACC` cycles, with byte enables set from the mask and the bus not driven.
- R5: Read data is sampled on the last cycle of the read window. A lane whose mask bit is clear returns zero. `rd_data` holds its value between reads.
- R6: After output enable rises at the end of a read, `ready` stays low for exactly `CYC_TURN` cycles, and the bus drive does not rise until at least `CYC_TURN` cycles after output enable rose.
- R7: A request is accepted only while `ready` is high. Requests made while busy have no effect on the strobes or the address. Chip select is high in the cycle in which a request is accepted.
- R8: `done` is high for exactly one cycle per request. For a write it is due `max(CYC_WE,CYC_DSU)+1` cycles after the accepting edge, and `ready` is already high in that cycle. For a read it is due `CYC_ACC` cycles after that edge.
- R9: Write data is on the bus for at least `CYC_DSU` cycles before write enable rises.
- R10: The address and the byte enables do not change while chip select is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request strobe, taken when `ready` is high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| req_mask | input | DATA_W/8 | Lane mask, bit 0 = bits 7:0, bit 1 = bits 15:8 |
| ready | output | 1 | Power-up done and sequencer idle |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | DATA_W | Captured read word, cleared lanes are zero |
| sram_addr | output | ADDR_W | Memory address bus |
| sram_cs_n | output | 1 | Chip select, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_we_n | output | 1 | Write enable, active low |
| sram_be_n | output | DATA_W/8 | Byte enables, active low |
| dq_out | output | DATA_W | Value driven onto the data bus |
| dq_oe | output | 1 | Bus drive enable |
| dq_in | input | DATA_W | Value sampled from the data bus |

## Verification
Every completion has a due cycle that is fixed by the accepting edge. A write finishes `max(CYC_WE,CYC_DSU)+1` cycles after it, a read `CYC_ACC` cycles after it, and `ready` returns `CYC_TURN` cycles after a read's `done`. The driver stores the due cycle with each expected item in the scoreboard queue. The monitor compares the cycle counter against it when it pops on `done`. All ports are sampled on the falling edge, so each registered change made at a rising edge is read half a period later.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WR,
    ST_WR_REL,
    ST_RD,
    ST_TURN
  } ctrl_state_t;

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_pwrup_gate.sv
module sram_pwrup_gate #(
  parameter int unsigned HOLD_CYC = 37500
) (
  input  logic clk,
  input  logic rst,
  output logic pwr_ok
);
  localparam int unsigned HOLD = (HOLD_CYC < 1) ? 1 : HOLD_CYC;
  localparam int CW = $clog2(HOLD + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      pwr_ok <= 1'b0;
    end else if (!pwr_ok) begin
      if (cnt == CW'(HOLD - 1)) pwr_ok <= 1'b1;
      else                      cnt    <= cnt + 1'b1;
    end
  end

  AST_PWR_STICKY: assert property (@(posedge clk) disable iff (rst)
    pwr_ok |=> pwr_ok); // R1

endmodule

// File: rtl/sram_read_capture.sv
module sram_read_capture #(
  parameter int DATA_W = 16,
  parameter int LANE_W = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cap_en,
  input  logic [DATA_W/LANE_W-1:0] lane_en,
  input  logic [DATA_W-1:0]        bus_in,
  output logic [DATA_W-1:0]        rd_data
);
  localparam int LANES = DATA_W / LANE_W;

  logic [LANE_W-1:0] lane_q [LANES];

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst)         lane_q[l] <= '0;
      else if (cap_en) lane_q[l] <= lane_en[l] ? bus_in[l*LANE_W +: LANE_W] : '0;
    end

    assign rd_data[l*LANE_W +: LANE_W] = lane_q[l];

    AST_LANE_HOLD: assert property (@(posedge clk) disable iff (rst)
      !cap_en |=> $stable(lane_q[l])); // R5
  end

endmodule

// File: rtl/sram_strobe_ctrl.sv
module sram_strobe_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W   = 20,
  parameter int DATA_W   = 16,
  parameter int CLK_MHZ  = 250,
  parameter int PWRUP_US = 150,
  parameter int CYC_WE   = 2,
  parameter int CYC_DSU  = 2,
  parameter int CYC_ACC  = 3,
  parameter int CYC_TURN = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  req_valid,
  input  logic                  req_write,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic [DATA_W-1:0]     req_wdata,
  input  logic [DATA_W/8-1:0]   req_mask,
  output logic                  ready,
  output logic                  done,
  output logic [DATA_W-1:0]     rd_data,
  output logic [ADDR_W-1:0]     sram_addr,
  output logic                  sram_cs_n,
  output logic                  sram_oe_n,
  output logic                  sram_we_n,
  output logic [DATA_W/8-1:0]   sram_be_n,
  output logic [DATA_W-1:0]     dq_out,
  output logic                  dq_oe,
  input  logic [DATA_W-1:0]     dq_in
);
  localparam int LANES = DATA_W / 8;
  localparam int unsigned HOLD_CYC = CLK_MHZ * PWRUP_US;
  localparam int unsigned WE_LEN   = umax(umax(CYC_WE, 1), umax(CYC_DSU, 1));
  localparam int unsigned ACC_LEN  = umax(CYC_ACC, 1);
  localparam int unsigned TURN_LEN = umax(CYC_TURN, 1);
  localparam int unsigned CNT_MAX  = umax(WE_LEN, umax(ACC_LEN, TURN_LEN));
  localparam int CNT_W = $clog2(CNT_MAX + 2);

  ctrl_state_t      state;
  logic [CNT_W-1:0] cnt;
  logic             pwr_ok;
  logic             cap_en;

  sram_pwrup_gate #(.HOLD_CYC(HOLD_CYC)) i_pwrup (
    .clk    (clk),
    .rst    (rst),
    .pwr_ok (pwr_ok)
  );

  assign ready  = pwr_ok && (state == ST_IDLE);
  assign cap_en = (state == ST_RD) && (cnt == '0);

  sram_read_capture #(.DATA_W(DATA_W), .LANE_W(8)) i_capture (
    .clk     (clk),
    .rst     (rst),
    .cap_en  (cap_en),
    .lane_en (~sram_be_n),
    .bus_in  (dq_in),
    .rd_data (rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      sram_addr <= '0;
      sram_cs_n <= 1'b1;
      sram_oe_n <= 1'b1;
      sram_we_n <= 1'b1;
      sram_be_n <= '1;
      dq_out    <= '0;
      dq_oe     <= 1'b0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (req_valid && ready) begin
            sram_addr <= req_addr;
            sram_be_n <= ~req_mask;
            sram_cs_n <= 1'b0;
            if (req_write) begin
              sram_we_n <= 1'b0;
              dq_out    <= req_wdata;
              dq_oe     <= 1'b1;
              cnt       <= CNT_W'(WE_LEN - 1);
              state     <= ST_WR;
            end else begin
              sram_oe_n <= 1'b0;
              cnt       <= CNT_W'(ACC_LEN - 1);
              state     <= ST_RD;
            end
          end
        end
        ST_WR: begin
          if (cnt == '0) begin
            sram_we_n <= 1'b1;
            state     <= ST_WR_REL;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_WR_REL: begin
          sram_cs_n <= 1'b1;
          sram_be_n <= '1;
          dq_oe     <= 1'b0;
          done      <= 1'b1;
          state     <= ST_IDLE;
        end
        ST_RD: begin
          if (cnt == '0) begin
            sram_cs_n <= 1'b1;
            sram_oe_n <= 1'b1;
            sram_be_n <= '1;
            done      <= 1'b1;
            cnt       <= CNT_W'(TURN_LEN - 1);
            state     <= ST_TURN;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_TURN: begin
          if (cnt == '0) state <= ST_IDLE;
          else           cnt   <= cnt - 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // Window counters for the timing checks
  logic [CNT_W-1:0] we_low_cnt;
  logic [CNT_W-1:0] oe_high_cnt;
  logic [CNT_W-1:0] drive_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      we_low_cnt  <= '0;
      oe_high_cnt <= '1;
      drive_cnt   <= '0;
    end else begin
      if (sram_we_n)              we_low_cnt <= '0;
      else if (we_low_cnt != '1)  we_low_cnt <= we_low_cnt + 1'b1;
      if (!sram_oe_n)             oe_high_cnt <= '0;
      else if (oe_high_cnt != '1) oe_high_cnt <= oe_high_cnt + 1'b1;
      if (!dq_oe)                 drive_cnt <= '0;
      else if (drive_cnt != '1)   drive_cnt <= drive_cnt + 1'b1;
    end
  end

  AST_NO_EARLY_ACCESS: assert property (@(posedge clk) disable iff (rst)
    !pwr_ok |-> sram_cs_n); // R1

  AST_WE_WIDTH: assert property (@(posedge clk) disable iff (rst)
    $rose(sram_we_n) |-> (we_low_cnt >= CNT_W'(WE_LEN)) && !sram_cs_n && dq_oe); // R2

  AST_WR_OE_HIGH: assert property (@(posedge clk) disable iff (rst)
    !sram_we_n |-> sram_oe_n && dq_oe); // R3

  AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (rst)
    !sram_oe_n |-> !dq_oe && sram_we_n && !sram_cs_n); // R4

  AST_TURNAROUND: assert property (@(posedge clk) disable iff (rst)
    $rose(dq_oe) |-> oe_high_cnt >= CNT_W'(TURN_LEN)); // R6

  AST_CS_GAP: assert property (@(posedge clk) disable iff (rst)
    (req_valid && ready) |-> sram_cs_n); // R7

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R8

  AST_DATA_SETUP: assert property (@(posedge clk) disable iff (rst)
    $rose(sram_we_n) |-> drive_cnt >= CNT_W'(umax(CYC_DSU, 1))); // R9

  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (rst)
    (!sram_cs_n && $past(!sram_cs_n)) |-> $stable(sram_addr) && $stable(sram_be_n)); // R10

endmodule

// File: tb/test_sram_strobe_ctrl.sv
module test_sram_strobe_ctrl;
  localparam int AW = 20;
  localparam int DW = 16;
  localparam int CLK_MHZ = 250;
  localparam int PWRUP_US = 150;
  localparam int HOLD = CLK_MHZ * PWRUP_US;
  localparam int T_WE = 2, T_DSU = 2, T_ACC = 3, T_TURN = 2;
  localparam int WLEN = (T_WE > T_DSU) ? T_WE : T_DSU;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic [1:0] req_mask = '0;
  logic ready, done, sram_cs_n, sram_oe_n, sram_we_n, dq_oe;
  logic [DW-1:0] rd_data, dq_out, dq_in;
  logic [AW-1:0] sram_addr;
  logic [1:0] sram_be_n;

  always #2 clk = ~clk;

  sram_strobe_ctrl #(
    .ADDR_W(AW), .DATA_W(DW), .CLK_MHZ(CLK_MHZ), .PWRUP_US(PWRUP_US),
    .CYC_WE(T_WE), .CYC_DSU(T_DSU), .CYC_ACC(T_ACC), .CYC_TURN(T_TURN)
  ) i_sram_strobe_ctrl (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask),
    .ready(ready), .done(done), .rd_data(rd_data), .sram_addr(sram_addr),
    .sram_cs_n(sram_cs_n), .sram_oe_n(sram_oe_n), .sram_we_n(sram_we_n),
    .sram_be_n(sram_be_n), .dq_out(dq_out), .dq_oe(dq_oe), .dq_in(dq_in)
  );

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;
  bit finished = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // Memory model: small array indexed by the low address bits
  logic [DW-1:0] mem [16];
  logic [DW-1:0] shadow [16];
  initial for (int i = 0; i < 16; i++) begin mem[i] = '0; shadow[i] = '0; end

  always @(posedge clk)
    if (!sram_cs_n && !sram_we_n && dq_oe)
      for (int l = 0; l < 2; l++)
        if (!sram_be_n[l]) mem[sram_addr[3:0]][l*8 +: 8] <= dq_out[l*8 +: 8];

  always_comb
    for (int l = 0; l < 2; l++)
      dq_in[l*8 +: 8] = (!sram_cs_n && !sram_oe_n && sram_we_n && !sram_be_n[l])
                        ? mem[sram_addr[3:0]][l*8 +: 8] : 8'hA5;

  // Scoreboard
  typedef struct { bit rd; logic [DW-1:0] data; int due; } exp_t;
  exp_t sbq[$];
  logic prev_done = 1'b0;

  always @(negedge clk) begin
    if (!rst && done) begin
      chk("R8 done one cycle", {31'd0, prev_done}, 32'd0);
      if (sbq.size() == 0) begin
        chk("R8 unexpected done", 32'd1, 32'd0);
      end else begin
        exp_t e;
        e = sbq.pop_front();
        chk("R8 done latency", cyc, e.due);
        if (e.rd) chk("R5 read data", {16'd0, rd_data}, {16'd0, e.data});
      end
    end
    prev_done = rst ? 1'b0 : done;
  end

  // Strobe monitor
  int we_low = 0, drive_run = 0, oe_rise_cyc = -1000;
  bit oe_bad = 0, prev_we_n = 1, prev_oe_n = 1, prev_dq_oe = 0;
  bit cs_prev_low = 0, addr_moved = 0;
  logic [AW-1:0] addr_hold;
  logic [1:0] be_hold;

  always @(negedge clk) begin
    if (!rst) begin
      if (!sram_we_n) begin
        we_low++;
        if (!sram_oe_n) oe_bad = 1;
      end
      if (!sram_oe_n && dq_oe) begin
        n_tests++; n_fail++;
        $display("FAIL R3 bus contention: actual dq_oe=1 expected 0");
      end
      if (sram_we_n && !prev_we_n) begin
        chk("R2 write strobe width", we_low, WLEN);
        chk("R2 cs held after strobe", {31'd0, sram_cs_n}, 32'd0);
        chk("R3 oe high during write", {31'd0, oe_bad}, 32'd0);
        chk("R9 data setup", {31'd0, (drive_run >= T_DSU)}, 32'd1);
        we_low = 0; oe_bad = 0;
      end
      if (sram_oe_n && !prev_oe_n) oe_rise_cyc = cyc;
      if (dq_oe && !prev_dq_oe)
        chk("R6 turnaround gap", {31'd0, ((cyc - oe_rise_cyc) >= T_TURN)}, 32'd1);
      drive_run = dq_oe ? drive_run + 1 : 0;
      if (!sram_cs_n) begin
        if (!cs_prev_low) begin addr_hold = sram_addr; be_hold = sram_be_n; end
        else if (sram_addr !== addr_hold || sram_be_n !== be_hold) addr_moved = 1;
      end else if (cs_prev_low) begin
        chk("R10 address stable", {31'd0, addr_moved}, 32'd0);
        addr_moved = 0;
      end
      cs_prev_low = !sram_cs_n;
      prev_we_n = sram_we_n; prev_oe_n = sram_oe_n; prev_dq_oe = dq_oe;
    end
  end

  task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [1:0] m);
    exp_t e;
    @(negedge clk);
    while (!ready) @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d; req_mask = m;
    @(posedge clk); #1;
    e.rd = 0; e.data = '0; e.due = cyc + WLEN + 1;
    sbq.push_back(e);
    for (int l = 0; l < 2; l++) if (m[l]) shadow[a[3:0]][l*8 +: 8] = d[l*8 +: 8];
    @(negedge clk);
    req_valid = 0;
    chk("R2 write strobes", {26'd0, sram_cs_n, sram_we_n, sram_oe_n, dq_oe, sram_be_n},
        {26'd0, 1'b0, 1'b0, 1'b1, 1'b1, ~m});
    chk("R2 write data", {16'd0, dq_out}, {16'd0, d});
    while (!done) @(negedge clk);
    chk("R8 ready at write done", {31'd0, ready}, 32'd1);
  endtask

  task automatic do_read(input logic [AW-1:0] a, input logic [1:0] m, input bit poke);
    exp_t e;
    int n;
    @(negedge clk);
    while (!ready) @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = a; req_mask = m;
    @(posedge clk); #1;
    e.rd = 1; e.due = cyc + T_ACC;
    for (int l = 0; l < 2; l++) e.data[l*8 +: 8] = m[l] ? shadow[a[3:0]][l*8 +: 8] : 8'h00;
    sbq.push_back(e);
    @(negedge clk);
    chk("R4 read strobes", {27'd0, sram_cs_n, sram_we_n, sram_oe_n, dq_oe, 1'b0},
        {27'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0});
    chk("R4 read byte enables", {30'd0, sram_be_n}, {30'd0, ~m});
    if (poke) begin
      req_valid = 1; req_write = 1; req_addr = ~a; req_mask = 2'b11;
      @(negedge clk);
      req_valid = 0;
      chk("R7 busy request ignored: we_n", {31'd0, sram_we_n}, 32'd1);
      chk("R7 busy request ignored: addr", {12'd0, sram_addr}, {12'd0, a});
    end else begin
      req_valid = 0;
    end
    while (!done) @(negedge clk);
    n = 0;
    while (!ready) begin @(negedge clk); n++; end
    chk("R6 ready after turnaround", n, T_TURN);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    bit bad;
    repeat (5) @(negedge clk);
    chk("R1 reset strobes", {27'd0, sram_cs_n, sram_oe_n, sram_we_n, dq_oe, done},
        {27'd0, 5'b11100});
    chk("R1 reset ready", {31'd0, ready}, 32'd0);
    req_valid = 1; req_write = 1; req_addr = 20'h00007; req_wdata = 16'hBEEF; req_mask = 2'b11;
    rst = 0;
    bad = 0;
    for (int i = 1; i < HOLD; i++) begin
      @(negedge clk);
      if (ready || !sram_cs_n) bad = 1;
      if (i == HOLD - 4) req_valid = 0;
    end
    chk("R1 held off during power-up", {31'd0, bad}, 32'd0);
    @(negedge clk);
    chk("R1 ready after power-up", {31'd0, ready}, 32'd1);
    chk("R1 early request left no write", {16'd0, mem[7]}, 32'd0);

    do_write(20'h00001, 16'h1234, 2'b11);
    do_write(20'h00002, 16'hABCD, 2'b01);
    do_write(20'h00002, 16'h5678, 2'b10);
    do_write(20'hFFFF3, 16'hFFFF, 2'b00);
    do_read(20'h00001, 2'b11, 0);
    do_read(20'h00002, 2'b11, 1);
    do_read(20'h00002, 2'b01, 0);
    do_read(20'h00002, 2'b10, 0);
    do_read(20'hFFFF3, 2'b11, 0);
    do_read(20'h00001, 2'b00, 0);
    do_write(20'h0000F, 16'hC3A5, 2'b11);
    do_read(20'h0000F, 2'b11, 1);
    do_write(20'h0000F, 16'h0F0F, 2'b10);
    do_read(20'h0000F, 2'b11, 0);

    repeat (4) @(negedge clk);
    chk("R8 all items completed", sbq.size(), 0);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule